// File: doc/BRIEF.md
# Serial GPIO Shift Engine

This block turns four pins into as many as eighty general-purpose lines. The four pins are a bus clock, a load strobe, a serial data output and a serial data input, and they connect to a chain of external shift registers. Software programs a control word with three fields: a clock divider, a line count in units of eight, and an enable. While the engine is enabled it repeats frames without a gap. Each frame starts with a load strobe. The engine then sends one output bit per bus clock pulse and takes in one input bit per pulse.

Lines are numbered from zero. Line i belongs to bank i>>5 and sits at bit position i&31 within it, so there are three banks of 32 bits and only the low 16 bits of the third bank are used. Writing a bank's value address sets the output latch for that bank. Reading the same address returns the input bits captured from the chain. A separate readback address returns the latched output bits. Captured input bits are committed to the value registers all at once at the end of a frame. The divider, the line count and the output latch are sampled once, when a frame starts.

Top module: `sgpio_engine`

## Requirements
- R1: After a synchronous reset, ser_clk, ser_load and ser_dout are low, and the control word and every bank read back as zero.
- R2: While enable (control bit 0) is 0, ser_clk, ser_load and ser_dout stay low from the cycle after the enable clear onward, and a frame cut short this way commits nothing.
- R3: A frame holds ser_load high for divider+1 cycles with ser_clk low. Every bit that follows spends divider+1 cycles with ser_clk low and then divider+1 cycles with ser_clk high. Frames follow each other without a gap. The divider is control bits 31:16.
- R4: A frame carries 8 times the line-count field (control bits 9:6) bits, limited to 80. A field of 0 gives frames that consist only of the load strobe, so ser_load stays high and ser_clk stays low.
- R5: Line 0 is sent first. ser_dout shows line i for the whole low half and high half of pulse i, and changes only while ser_clk is low. It is 0 during the load strobe.
- R6: ser_din is captured at the cycle where ser_clk rises. The bit captured at pulse i becomes line i of the value registers.
- R7: The value registers change only at the end of a frame, in a single update. A read in the middle of a frame returns the previous frame's inputs.
- R8: A write to address 1, 2 or 3 sets output latch bank 0, 1 or 2. Addresses 5, 6 and 7 read those latches back. Addresses 1 to 3 read the captured inputs, not the latch.
- R9: A change to the latch, the divider or the line count made during a frame takes effect at the next frame start.
- R10: Address 0 holds the control word. Only bits 31:16, 9:6 and 0 are kept, and all other bits read as 0. Bits 31:16 of the third bank read as 0.
- R11: reg_rdata shows the word at reg_addr one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| ser_clk | output | 1 | Serial bus clock |
| ser_load | output | 1 | Frame load strobe |
| ser_dout | output | 1 | Serial output data |
| ser_din | input | 1 | Serial input data |

## Verification
The bench builds the block with the default 80 lines, so the clamp of a line-count field of 15 and the 16-bit third bank are both reachable. It programs dividers of 0, 1 and 2, which keeps frames short enough to cover many boundaries while still giving half periods of several cycles. These settings exercise frames of 16 lines, 80 lines and no lines, writes made in the middle of a frame, and disabling the engine in the middle of a frame. A behavioural model of the external shift chain feeds known input patterns. That model compares the pins against a predicted frame on every clock.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
  localparam int DIV_W    = 16;
  localparam int DIV_LSB  = 16;
  localparam int CNT_W    = 4;
  localparam int CNT_LSB  = 6;
  localparam int EN_BIT   = 0;
  localparam int ADDR_W   = 3;
  localparam int VAL_BASE = 1;
  localparam int RB_BASE  = 5;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_LOW,
    PH_HIGH
  } phase_t;
endpackage

// File: rtl/sgpio_regs.sv
module sgpio_regs
  import sgpio_pkg::*;
#(
  parameter int MAX_LINES = 80
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 en_o,
  output logic [DIV_W-1:0]     div_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [MAX_LINES-1:0] lines_o,
  input  logic [MAX_LINES-1:0] cap_i,
  input  logic                 commit_i
);
  // Banks are addressed at VAL_BASE+b and RB_BASE+b; three fit the 3-bit map.
  localparam int BANKS = (MAX_LINES + 31) / 32;
  localparam int FLAT  = BANKS * 32;
  localparam logic [FLAT-1:0] IMPL_MASK = (FLAT'(1) << MAX_LINES) - FLAT'(1);

  logic             en_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FLAT-1:0]  out_latch;
  logic [FLAT-1:0]  in_val;
  logic [31:0]      rd_word;
  logic [31:0]      rdata_q;
  logic             unused_bits;

  assign unused_bits = ^{wdata[DIV_LSB-1:CNT_LSB+CNT_W], wdata[CNT_LSB-1:EN_BIT+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      div_q     <= '0;
      cnt_q     <= '0;
      out_latch <= '0;
      in_val    <= '0;
      rdata_q   <= '0;
    end else begin
      if (wr_en && addr == ADDR_W'(0)) begin
        en_q  <= wdata[EN_BIT];
        div_q <= wdata[DIV_LSB +: DIV_W];
        cnt_q <= wdata[CNT_LSB +: CNT_W];
      end
      for (int b = 0; b < BANKS; b++) begin
        if (wr_en && addr == ADDR_W'(VAL_BASE + b))
          out_latch[b*32 +: 32] <= wdata & IMPL_MASK[b*32 +: 32];
      end
      if (commit_i)
        in_val <= FLAT'(cap_i);
      rdata_q <= rd_word;
    end
  end

  always_comb begin
    rd_word = '0;
    if (addr == ADDR_W'(0)) begin
      rd_word[DIV_LSB +: DIV_W] = div_q;
      rd_word[CNT_LSB +: CNT_W] = cnt_q;
      rd_word[EN_BIT]           = en_q;
    end
    for (int b = 0; b < BANKS; b++) begin
      if (addr == ADDR_W'(VAL_BASE + b)) rd_word = in_val[b*32 +: 32];
      if (addr == ADDR_W'(RB_BASE + b))  rd_word = out_latch[b*32 +: 32];
    end
  end

  assign rdata   = rdata_q;
  assign en_o    = en_q;
  assign div_o   = div_q;
  assign cnt_o   = cnt_q;
  assign lines_o = out_latch[MAX_LINES-1:0];

  // R7
  value_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(in_val));
endmodule

// File: rtl/sgpio_shifter.sv
module sgpio_shifter
  import sgpio_pkg::*;
#(
  parameter int MAX_LINES = 80
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [MAX_LINES-1:0] lines_i,
  input  logic                 sdin_i,
  output logic                 sclk_o,
  output logic                 sload_o,
  output logic                 sdout_o,
  output logic [MAX_LINES-1:0] cap_o,
  output logic                 commit_o
);
  localparam int IDX_W = $clog2(MAX_LINES + 1);

  phase_t               phase;
  logic [DIV_W-1:0]     hcnt;
  logic [DIV_W-1:0]     div_q;
  logic [IDX_W-1:0]     nbits;
  logic [IDX_W-1:0]     bitidx;
  logic [IDX_W-1:0]     bitidx_nx;
  logic [IDX_W-1:0]     nb_next;
  logic [MAX_LINES-1:0] snap;
  logic [MAX_LINES-1:0] cap;
  logic                 sclk_q, sload_q, sdout_q;
  logic                 half_done;
  logic                 last_bit;
  logic                 capture_now;
  int                   req_lines;

  always_comb begin
    req_lines = int'(cnt_i) * 8;
    nb_next   = IDX_W'((req_lines > MAX_LINES) ? MAX_LINES : req_lines);
  end

  assign half_done   = (hcnt == div_q);
  assign bitidx_nx   = bitidx + 1'b1;
  assign last_bit    = (bitidx == nbits - 1'b1);
  assign capture_now = en_i && phase == PH_LOW && half_done;
  assign commit_o    = en_i && half_done &&
                       ((phase == PH_HIGH && last_bit) ||
                        (phase == PH_LOAD && nbits == '0));

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      phase   <= PH_IDLE;
      hcnt    <= '0;
      div_q   <= '0;
      nbits   <= '0;
      bitidx  <= '0;
      snap    <= '0;
      sclk_q  <= 1'b0;
      sload_q <= 1'b0;
      sdout_q <= 1'b0;
    end else begin
      hcnt <= half_done ? '0 : hcnt + 1'b1;
      unique case (phase)
        PH_IDLE: begin
          phase   <= PH_LOAD;
          sload_q <= 1'b1;
          sdout_q <= 1'b0;
          div_q   <= div_i;
          nbits   <= nb_next;
          snap    <= lines_i;
          hcnt    <= '0;
        end
        PH_LOAD: begin
          if (half_done) begin
            if (nbits == '0) begin
              sload_q <= 1'b1;
              div_q   <= div_i;
              nbits   <= nb_next;
              snap    <= lines_i;
            end else begin
              phase   <= PH_LOW;
              sload_q <= 1'b0;
              sdout_q <= snap[0];
              bitidx  <= '0;
            end
          end
        end
        PH_LOW: begin
          if (half_done) begin
            phase  <= PH_HIGH;
            sclk_q <= 1'b1;
          end
        end
        PH_HIGH: begin
          if (half_done) begin
            sclk_q <= 1'b0;
            if (last_bit) begin
              phase   <= PH_LOAD;
              sload_q <= 1'b1;
              sdout_q <= 1'b0;
              div_q   <= div_i;
              nbits   <= nb_next;
              snap    <= lines_i;
            end else begin
              phase   <= PH_LOW;
              bitidx  <= bitidx_nx;
              sdout_q <= snap[bitidx_nx];
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cap <= '0;
    else if (capture_now)
      cap[bitidx] <= sdin_i;
  end

  assign cap_o   = cap;
  assign sclk_o  = sclk_q;
  assign sload_o = sload_q;
  assign sdout_o = sdout_q;

  // R2
  disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!sclk_o && !sload_o && !sdout_o));

  // R3
  strobe_clk_excl_chk: assert property (@(posedge clk) disable iff (rst)
    sload_o |-> !sclk_o);

  // R5
  dout_change_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sdout_o != $past(sdout_o)) |-> !sclk_o);

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOW || phase == PH_HIGH) |-> (bitidx < nbits));
endmodule

// File: rtl/sgpio_engine.sv
module sgpio_engine
  import sgpio_pkg::*;
#(
  parameter int MAX_LINES = 80
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        ser_clk,
  output logic        ser_load,
  output logic        ser_dout,
  input  logic        ser_din
);
  logic                 en;
  logic [DIV_W-1:0]     div;
  logic [CNT_W-1:0]     cnt;
  logic [MAX_LINES-1:0] lines;
  logic [MAX_LINES-1:0] cap;
  logic                 commit;

  sgpio_regs #(.MAX_LINES(MAX_LINES)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .en_o     (en),
    .div_o    (div),
    .cnt_o    (cnt),
    .lines_o  (lines),
    .cap_i    (cap),
    .commit_i (commit)
  );

  sgpio_shifter #(.MAX_LINES(MAX_LINES)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en),
    .div_i    (div),
    .cnt_i    (cnt),
    .lines_i  (lines),
    .sdin_i   (ser_din),
    .sclk_o   (ser_clk),
    .sload_o  (ser_load),
    .sdout_o  (ser_dout),
    .cap_o    (cap),
    .commit_o (commit)
  );
endmodule

// File: tb/sgpio_engine_tb.sv
module sgpio_engine_tb;
  localparam int LINES = 80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ser_clk, ser_load, ser_dout, ser_din;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sgpio_engine u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_clk(ser_clk),
    .ser_load(ser_load), .ser_dout(ser_dout), .ser_din(ser_din)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // register model, one and two edges deep
  logic        m_en, m_en_d;
  logic [15:0] m_div, m_div_d;
  logic [3:0]  m_cnt, m_cnt_d;
  logic [95:0] m_out, m_out_d;

  always @(posedge clk) begin
    if (rst) begin
      m_en <= 0; m_en_d <= 0; m_div <= 0; m_div_d <= 0;
      m_cnt <= 0; m_cnt_d <= 0; m_out <= 0; m_out_d <= 0;
    end else begin
      m_en_d <= m_en; m_div_d <= m_div; m_cnt_d <= m_cnt; m_out_d <= m_out;
      if (reg_wr) begin
        if (reg_addr == 3'd0) begin
          m_en <= reg_wdata[0]; m_div <= reg_wdata[31:16]; m_cnt <= reg_wdata[9:6];
        end
        for (int b = 0; b < 3; b++)
          if (reg_addr == 3'(1 + b))
            for (int j = 0; j < 32; j++)
              m_out[b*32+j] <= (b*32 + j < LINES) ? reg_wdata[j] : 1'b0;
      end
    end
  end

  // expected pin triples {clk, load, dout}
  logic [2:0] q[$];

  task automatic build_frame();
    int n;
    n = int'(m_cnt_d) * 8;
    if (n > LINES) n = LINES;
    for (int d = 0; d <= int'(m_div_d); d++) q.push_back(3'b010);
    for (int i = 0; i < n; i++) begin
      for (int d = 0; d <= int'(m_div_d); d++) q.push_back({2'b00, m_out_d[i]});
      for (int d = 0; d <= int'(m_div_d); d++) q.push_back({2'b10, m_out_d[i]});
    end
  endtask

  // board-side chain model
  logic [LINES-1:0] board_in = '0;
  logic [LINES-1:0] got = '0;
  logic [LINES-1:0] last_got = '0;
  int k = 0;
  int pulses = 0, pulses_last = 0;
  int load_run = 0, load_len_last = 0;
  int high_run = 0, high_len_last = 0;
  int frame_starts = 0;
  logic prev_clk = 0, prev_load = 0;

  assign ser_din = (k < LINES) ? board_in[k] : 1'b0;

  always @(negedge clk) begin : pin_model
    logic [2:0] e;
    if (rst) begin
      q.delete(); k = 0; prev_clk = 0; prev_load = 0;
    end else begin
      if (!m_en_d) begin
        q.delete(); e = 3'b000;
      end else begin
        if (q.size() == 0) build_frame();
        e = q.pop_front();
      end
      chk({ser_clk, ser_load, ser_dout} == e, "R3 R5 R2 per-cycle pins",
          96'({ser_clk, ser_load, ser_dout}), 96'(e));
      if (ser_load && !prev_load) begin
        frame_starts++; pulses_last = pulses; pulses = 0; last_got = got;
      end
      if (ser_load) k = 0;
      if (ser_clk && !prev_clk) begin
        if (k < LINES) got[k] = ser_dout;
        k++; pulses++;
      end
      if (ser_load) load_run++;
      else begin if (prev_load) load_len_last = load_run; load_run = 0; end
      if (ser_clk) high_run++;
      else begin if (prev_clk) high_len_last = high_run; high_run = 0; end
      prev_clk = ser_clk; prev_load = ser_load;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(posedge clk); @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = frame_starts + n;
    while (frame_starts < target) @(negedge clk);
  endtask

  logic [31:0] d;

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk({ser_clk, ser_load, ser_dout} == 3'b000, "R1 pins in reset",
        96'({ser_clk, ser_load, ser_dout}), 0);
    rst = 1'b0;
    rd(3'd0, d); chk(d == 0, "R1 ctrl after reset", 96'(d), 0);
    rd(3'd5, d); chk(d == 0, "R1 readback after reset", 96'(d), 0);

    wr(3'd1, 32'hA5C3_0F96); wr(3'd2, 32'h1234_5678); wr(3'd3, 32'hFFFF_BEEF);
    rd(3'd5, d); chk(d == 32'hA5C3_0F96, "R8 readback bank0", 96'(d), 96'h0A5C30F96);
    rd(3'd6, d); chk(d == 32'h1234_5678, "R8 readback bank1", 96'(d), 96'h12345678);
    rd(3'd7, d); chk(d == 32'h0000_BEEF, "R10 bank2 upper bits", 96'(d), 96'h0000BEEF);
    rd(3'd1, d); chk(d == 0, "R8 value read is inputs", 96'(d), 0);

    wr(3'd0, 32'h0001_FCBE);
    rd(3'd0, d); chk(d == 32'h0001_0080, "R10 ctrl fields", 96'(d), 96'h00010080);

    // R11 one-cycle read latency
    @(negedge clk); reg_addr = 3'd5; #1;
    chk(reg_rdata == 32'h0001_0080, "R11 old word before edge", 96'(reg_rdata), 96'h00010080);
    @(posedge clk); @(negedge clk);
    chk(reg_rdata == 32'hA5C3_0F96, "R11 new word after edge", 96'(reg_rdata), 96'h0A5C30F96);

    // 16-line frames, divider 1
    board_in = {16'hC0DE, 32'h0BAD_F00D, 32'h1357_9BDF};
    wr(3'd0, 32'h0001_0081);
    wait_frames(2);
    chk(last_got[15:0] == 16'h0F96, "R5 shifted order", 96'(last_got[15:0]), 96'h0F96);
    chk(pulses_last == 16, "R4 sixteen pulses", 96'(pulses_last), 16);
    rd(3'd1, d); chk(d == 32'h0000_9BDF, "R6 captured bank0", 96'(d), 96'h9BDF);

    // R7 no partial frame visible
    wait_frames(1);
    board_in = {16'h7E57, 32'hFACE_CAFE, 32'h2468_ACE0};
    repeat (10) @(negedge clk);
    rd(3'd1, d); chk(d == 32'h0000_9BDF, "R7 mid-frame read old", 96'(d), 96'h9BDF);
    wait_frames(1);
    rd(3'd1, d); chk(d == 32'h0000_ACE0, "R7 after frame new", 96'(d), 96'hACE0);

    // R9 mid-frame changes
    wait_frames(1);
    repeat (5) @(negedge clk);
    wr(3'd1, 32'h0F0F_3C3C);
    wr(3'd0, 32'h0000_0281);
    wait_frames(1);
    chk(last_got[15:0] == 16'h0F96, "R9 in-flight frame keeps old latch",
        96'(last_got[15:0]), 96'h0F96);
    chk(pulses_last == 16, "R9 in-flight frame keeps old count", 96'(pulses_last), 16);
    wait_frames(1);
    chk(last_got == {16'hBEEF, 32'h1234_5678, 32'h0F0F_3C3C}, "R9 R5 next frame new latch",
        96'(last_got), 96'({16'hBEEF, 32'h1234_5678, 32'h0F0F_3C3C}));
    chk(pulses_last == 80, "R4 eighty pulses", 96'(pulses_last), 80);
    rd(3'd1, d); chk(d == 32'h2468_ACE0, "R6 bank0 full", 96'(d), 96'h2468ACE0);
    rd(3'd2, d); chk(d == 32'hFACE_CAFE, "R6 bank1", 96'(d), 96'hFACECAFE);
    rd(3'd3, d); chk(d == 32'h0000_7E57, "R6 bank2", 96'(d), 96'h7E57);

    // R3 divider 2 timing
    wr(3'd0, 32'h0002_0081);
    wait_frames(2);
    chk(load_len_last == 3, "R3 load strobe length", 96'(load_len_last), 3);
    chk(high_len_last == 3, "R3 high half length", 96'(high_len_last), 3);
    chk(pulses_last == 16, "R4 count after divider change", 96'(pulses_last), 16);

    // R4 clamp of field 15
    wr(3'd0, 32'h0000_03C1);
    wait_frames(2);
    chk(pulses_last == 80, "R4 clamp to 80", 96'(pulses_last), 80);

    // R4 field zero
    wr(3'd0, 32'h0000_0001);
    repeat (200) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      chk(ser_load && !ser_clk, "R4 load-only frames", 96'({ser_clk, ser_load}), 96'b01);
      @(negedge clk);
    end

    // R2 disable mid-frame
    wr(3'd0, 32'h0001_0081);
    wait_frames(1);
    board_in = '1;
    repeat (10) @(negedge clk);
    wr(3'd0, 32'h0001_0080);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk({ser_clk, ser_load, ser_dout} == 3'b000, "R2 idle after disable",
          96'({ser_clk, ser_load, ser_dout}), 0);
      @(negedge clk);
    end
    rd(3'd1, d); chk(d == 32'h2468_ACE0, "R2 R7 aborted frame not committed", 96'(d), 96'h2468ACE0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R3 act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule